// File: doc/BRIEF.md
# One-of-Four Return-to-Zero Bus Codec

This block moves binary words over a wide wire bus in which every pair of data bits travels as a group of four wires. Exactly one wire of a group is high while a word is on the bus. Between words, every wire goes back to zero. The receiver can therefore tell from the wires alone when a word has fully arrived and when the bus is empty again. No timing margin is needed for that.

The transmitter half takes a binary word when the bus is empty and the acknowledge is low. It drives the one-hot code and holds it until the acknowledge rises, then drives the all-zero spacer. The receiver half watches the bus. Once every group shows a wire, it decodes the word, or flags it as malformed, and raises the acknowledge. It lowers the acknowledge when the whole bus reads zero again.

Both halves share one clock. In a system, one codec's transmitter wires connect to another codec's receiver, and the acknowledge runs back the other way.

Top module: `quad_rtz_codec`

## Requirements
- R1: Group g of `tx_wires` (lanes 4g+3..4g, group 0 at the least significant lanes) carries data bits 2g+1..2g of the accepted word, encoded as 00→0001, 01→0010, 10→0100, 11→1000.
- R2: After reset, `tx_wires` is all zero, `rx_ack`, `rx_valid` and `rx_invalid` are low, and `tx_ready` is high while `tx_ack` is low.
- R3: In the clock edge after the transmitter samples `tx_ack` high while sending, `tx_wires` returns to all zero.
- R4: While sending and `tx_ack` is low, `tx_wires` keeps the code word unchanged.
- R5: `tx_ready` is high only when the transmitter bus is all zero and `tx_ack` is low. A `tx_valid` while `tx_ready` is low is ignored, and `tx_wires` does not change.
- R6: When every group of `rx_wires` has exactly one high wire and `rx_ack` is low, the next edge raises `rx_ack` and gives a one-cycle `rx_valid` with the decoded word on `rx_data`.
- R7: While any group of `rx_wires` reads 0000, the receiver neither raises `rx_ack` nor pulses `rx_valid` or `rx_invalid`.
- R8: When no group reads 0000 but some group has two or more high wires, the next edge gives a one-cycle `rx_invalid`, raises `rx_ack`, gives no `rx_valid`, and leaves `rx_data` unchanged.
- R9: `rx_ack` falls on the edge after all groups read 0000. While any wire is still high, `rx_ack` stays high and no new `rx_valid` appears.
- R10: When the transmitter is looped back to the receiver, each word costs exactly two transitions per group: one rise and one fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_valid | input | 1 | Binary word offered to the transmitter |
| tx_data | input | WORD_W | Binary word to send |
| tx_ready | output | 1 | Transmitter takes the word at this edge |
| tx_wires | output | 2*WORD_W | Outgoing one-of-four bus |
| tx_ack | input | 1 | Acknowledge from the far receiver |
| rx_wires | input | 2*WORD_W | Incoming one-of-four bus |
| rx_ack | output | 1 | Acknowledge to the far transmitter |
| rx_valid | output | 1 | One-cycle pulse: a decoded word is on rx_data |
| rx_invalid | output | 1 | One-cycle pulse: a malformed word was seen |
| rx_data | output | WORD_W | Last decoded word |

## Verification
Completion detection and invalid-code detection can resolve in the same cycle. This happens when the last empty group fills while another group already carries two high wires. The bench drives the receiver bus directly in this way. It first leaves one group empty and gives another group two wires, then fills the missing group. The check expects silence before that last fill. After it, the check expects `rx_invalid` with no `rx_valid`, a raised acknowledge and an unchanged `rx_data`. In loopback, a scoreboard follows a stream of words through the whole four-phase cycle and counts the wire transitions.

// File: rtl/quad_rtz_pkg.sv
package quad_rtz_pkg;

    typedef enum logic {
        TX_IDLE = 1'b0,
        TX_SEND = 1'b1
    } tx_state_e;

    // two binary bits -> one hot wire of a group of four
    function automatic logic [3:0] quad_encode(input logic [1:0] bits);
        return 4'b0001 << bits;
    endfunction

endpackage

// File: rtl/quad_rtz_group.sv
module quad_rtz_group (
    input  logic [3:0] wires,
    output logic       empty,
    output logic       multi,
    output logic [1:0] value
);
    always_comb begin
        empty = (wires == 4'b0000);
        multi = ($countones(wires) > 1);
        value = {wires[3] | wires[2], wires[3] | wires[1]};
    end
endmodule

// File: rtl/quad_rtz_tx.sv
module quad_rtz_tx
    import quad_rtz_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_valid,
    input  logic [WORD_W-1:0]   tx_data,
    output logic                tx_ready,
    output logic [2*WORD_W-1:0] tx_wires,
    input  logic                tx_ack
);
    localparam int GROUPS = WORD_W / 2;
    localparam int LANES  = 4 * GROUPS;

    typedef struct packed {
        tx_state_e        st;
        logic [LANES-1:0] wires;
    } tx_regs_t;

    tx_regs_t r_q, r_d;
    logic [LANES-1:0] code;

    for (genvar g = 0; g < GROUPS; g++) begin : g_enc
        assign code[4*g +: 4] = quad_encode(tx_data[2*g +: 2]);
    end

    always_comb begin
        r_d      = r_q;
        tx_ready = (r_q.st == TX_IDLE) && !tx_ack;
        case (r_q.st)
            TX_IDLE: if (tx_valid && tx_ready) begin
                r_d.st    = TX_SEND;
                r_d.wires = code;
            end
            TX_SEND: if (tx_ack) begin
                r_d.st    = TX_IDLE;
                r_d.wires = '0;
            end
            default: r_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tx_wires = r_q.wires;

    a_r3_null_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == TX_SEND && tx_ack) |=> (tx_wires == '0));
    a_r4_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == TX_SEND && !tx_ack) |=> $stable(tx_wires));
    a_r5_accept_on_null: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |-> (tx_wires == '0));
    for (genvar g = 0; g < GROUPS; g++) begin : g_chk
        a_r1_group_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(tx_wires[4*g +: 4]));
    end
endmodule

// File: rtl/quad_rtz_rx.sv
module quad_rtz_rx #(
    parameter int WORD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2*WORD_W-1:0] rx_wires,
    output logic                rx_ack,
    output logic                rx_valid,
    output logic                rx_invalid,
    output logic [WORD_W-1:0]   rx_data
);
    localparam int GROUPS = WORD_W / 2;

    typedef struct packed {
        logic              ack;
        logic              valid;
        logic              invalid;
        logic [WORD_W-1:0] data;
    } rx_regs_t;

    rx_regs_t r_q, r_d;
    logic [GROUPS-1:0] empty_v, multi_v;
    logic [WORD_W-1:0] dec;
    logic all_empty, full, any_multi;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        quad_rtz_group u_grp (
            .wires (rx_wires[4*g +: 4]),
            .empty (empty_v[g]),
            .multi (multi_v[g]),
            .value (dec[2*g +: 2])
        );
    end

    always_comb begin
        all_empty = &empty_v;
        full      = ~|empty_v;
        any_multi = |multi_v;
        r_d         = r_q;
        r_d.valid   = 1'b0;
        r_d.invalid = 1'b0;
        if (!r_q.ack) begin
            if (full) begin
                r_d.ack = 1'b1;
                if (any_multi) begin
                    r_d.invalid = 1'b1;
                end else begin
                    r_d.valid = 1'b1;
                    r_d.data  = dec;
                end
            end
        end else if (all_empty) begin
            r_d.ack = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rx_ack     = r_q.ack;
    assign rx_valid   = r_q.valid;
    assign rx_invalid = r_q.invalid;
    assign rx_data    = r_q.data;

    a_r6_valid_on_ack_rise: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $rose(rx_ack));
    a_r7_wait_partial: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ack && !full) |=> (!rx_ack && !rx_valid && !rx_invalid));
    a_r8_exclusive_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_invalid));
    a_r9_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ack && all_empty) |=> !rx_ack);
    a_r9_ack_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ack && !all_empty) |=> (rx_ack && !rx_valid));
endmodule

// File: rtl/quad_rtz_codec.sv
module quad_rtz_codec #(
    parameter int WORD_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tx_valid,
    input  logic [WORD_W-1:0]   tx_data,
    output logic                tx_ready,
    output logic [2*WORD_W-1:0] tx_wires,
    input  logic                tx_ack,
    input  logic [2*WORD_W-1:0] rx_wires,
    output logic                rx_ack,
    output logic                rx_valid,
    output logic                rx_invalid,
    output logic [WORD_W-1:0]   rx_data
);
    quad_rtz_tx #(.WORD_W(WORD_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_valid (tx_valid),
        .tx_data  (tx_data),
        .tx_ready (tx_ready),
        .tx_wires (tx_wires),
        .tx_ack   (tx_ack)
    );

    quad_rtz_rx #(.WORD_W(WORD_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_wires   (rx_wires),
        .rx_ack     (rx_ack),
        .rx_valid   (rx_valid),
        .rx_invalid (rx_invalid),
        .rx_data    (rx_data)
    );
endmodule

// File: tb/quad_rtz_codec_test.sv
module quad_rtz_codec_test;
    localparam int W = 8;
    localparam int L = 2 * W;
    localparam int G = W / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_valid = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic tx_ready, rx_ack, rx_valid, rx_invalid, tx_ack;
    logic [L-1:0] tx_wires, rx_wires;
    logic [W-1:0] rx_data;

    bit loop = 1'b0;
    logic [L-1:0] man_wires = '0;
    logic man_ack = 1'b0;

    assign rx_wires = loop ? tx_wires : man_wires;
    assign tx_ack   = loop ? rx_ack : man_ack;

    always #10 clk = ~clk;  // 50 MHz

    quad_rtz_codec #(.WORD_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .tx_wires(tx_wires), .tx_ack(tx_ack),
        .rx_wires(rx_wires), .rx_ack(rx_ack), .rx_valid(rx_valid),
        .rx_invalid(rx_invalid), .rx_data(rx_data)
    );

    int n_chk = 0, n_fail = 0;
    logic [W-1:0] exp_q[$];
    int toggles = 0;
    logic [L-1:0] prev_w = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [L-1:0] enc_word(input logic [W-1:0] d);
        logic [L-1:0] r = '0;
        for (int g = 0; g < G; g++) r[4*g +: 4] = 4'b0001 << d[2*g +: 2];
        return r;
    endfunction

    // driver: waits for ready, offers one word, scoreboards it in loopback
    task automatic send_word(input logic [W-1:0] d);
        do @(negedge clk); while (!tx_ready);
        tx_valid = 1'b1;
        tx_data  = d;
        if (loop) exp_q.push_back(d);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    // monitor: compares received words against the queue
    always @(negedge clk) begin
        if (rst_n) begin
            toggles += $countones(tx_wires ^ prev_w);
            prev_w = tx_wires;
            if (loop && rx_invalid) chk(1'b0, "R8 no invalid in loopback", 1, 0);
            if (loop && rx_valid) begin
                if (exp_q.size() == 0) chk(1'b0, "R6 unexpected word", {24'b0, rx_data}, 0);
                else begin
                    logic [W-1:0] e;
                    e = exp_q.pop_front();
                    chk(rx_data == e, "R6 loopback data", {24'b0, rx_data}, {24'b0, e});
                end
            end
        end
    end

    task automatic run_all();
        logic [L-1:0] held;
        logic [W-1:0] last;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        chk(tx_wires == '0, "R2 tx_wires", tx_wires, 0);
        chk(!rx_ack && !rx_valid && !rx_invalid, "R2 rx flags", {rx_ack, rx_valid, rx_invalid}, 0);
        chk(tx_ready, "R2 tx_ready", tx_ready, 1);

        // R1 / R4 / R5 / R3 with the acknowledge driven by hand
        send_word(8'h1B);
        chk(tx_wires == enc_word(8'h1B), "R1 encode 1B", tx_wires, enc_word(8'h1B));
        chk(tx_wires == 16'h1248, "R1 lane positions", tx_wires, 16'h1248);
        held = tx_wires;
        tx_valid = 1'b1; tx_data = 8'hE4;
        repeat (2) @(negedge clk);
        tx_valid = 1'b0;
        chk(tx_wires == held, "R4 hold while ack low", tx_wires, held);
        chk(!tx_ready, "R5 not ready while sending", tx_ready, 0);
        man_ack = 1'b1;
        @(negedge clk);
        chk(tx_wires == '0, "R3 null after ack", tx_wires, 0);
        tx_valid = 1'b1; tx_data = 8'h55;
        @(negedge clk);
        tx_valid = 1'b0;
        chk(tx_wires == '0, "R5 ignored while ack high", tx_wires, 0);
        chk(!tx_ready, "R5 ready low while ack high", tx_ready, 0);
        man_ack = 1'b0;
        @(negedge clk);
        chk(tx_ready, "R5 ready after ack low", tx_ready, 1);
        send_word(8'hE4);
        chk(tx_wires == enc_word(8'hE4), "R1 encode E4", tx_wires, enc_word(8'hE4));
        man_ack = 1'b1;
        @(negedge clk);
        man_ack = 1'b0;

        // receiver driven by hand: partial word, then complete
        man_wires = 16'h0001;
        @(negedge clk);
        chk(!rx_ack && !rx_valid, "R7 partial 1", {rx_ack, rx_valid}, 0);
        man_wires = 16'h0201;
        @(negedge clk);
        chk(!rx_ack && !rx_valid && !rx_invalid, "R7 partial 2", {rx_ack, rx_valid, rx_invalid}, 0);
        man_wires = 16'h8421;  // groups: 00,01,10,11 -> word 8'hE4
        @(negedge clk);
        chk(rx_valid && rx_ack, "R6 complete", {rx_valid, rx_ack}, 3);
        chk(rx_data == 8'hE4, "R6 decode", rx_data, 8'hE4);
        man_wires = 16'h0400;
        @(negedge clk);
        chk(rx_ack && !rx_valid, "R9 ack held", {rx_ack, rx_valid}, 2);
        man_wires = 16'h0000;
        @(negedge clk);
        chk(!rx_ack, "R9 ack drop", rx_ack, 0);
        last = rx_data;

        // invalid and completion resolving in the same cycle
        man_wires = 16'h0031;  // group1 has two wires, groups 2,3 empty
        @(negedge clk);
        chk(!rx_ack && !rx_invalid, "R7 invalid not yet full", {rx_ack, rx_invalid}, 0);
        man_wires = 16'h1231;
        @(negedge clk);
        chk(rx_invalid && !rx_valid && rx_ack, "R8 invalid flagged", {rx_invalid, rx_valid, rx_ack}, 5);
        chk(rx_data == last, "R8 data kept", rx_data, last);
        @(negedge clk);
        chk(!rx_invalid, "R8 single pulse", rx_invalid, 0);
        man_wires = '0;
        @(negedge clk);
        chk(!rx_ack, "R9 ack drop after invalid", rx_ack, 0);

        // loopback stream with transition count
        loop = 1'b1;
        @(negedge clk);
        toggles = 0;
        send_word(8'h00);
        send_word(8'hFF);
        send_word(8'hA5);
        send_word(8'h3C);
        send_word(8'h96);
        repeat (12) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all words delivered", exp_q.size(), 0);
        chk(toggles == 5 * 2 * G, "R10 two transitions per group", toggles, 5 * 2 * G);
        chk(tx_wires == '0 && !rx_ack, "R9 bus idle at end", {tx_wires, rx_ack}, 0);
    endtask

    initial begin
        bit timeout = 1'b0;
        fork
            run_all();
            begin repeat (100000) @(posedge clk); timeout = 1'b1; end
        join_any
        disable fork;
        if (timeout) chk(1'b0, "watchdog", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule